// File: doc/BRIEF.md
# Dual-Clock Latched Serial-to-Parallel Register

This block turns a serial bit stream into a parallel word in two steps. A shift register of `N` stages takes one serial bit per rising edge of its shift clock input. A separate storage register copies the whole shift register on each rising edge of its own storage clock input, and only the storage register drives the parallel output. Each register has its own active-low clear. A serial output taken from the last shift stage lets several instances be chained. The next instance then shifts on the same clock and picks up the bit that falls out of the stage before it.

The block runs on one system clock `clk`. The four control pins are treated as asynchronous levels. Each passes through a two-flop synchronizer. The two clock pins then feed an edge-tracking state machine with states `LVL_LOW` and `LVL_HIGH`. The move `LVL_LOW -> LVL_HIGH` issues a one-cycle rise strobe. The move `LVL_HIGH -> LVL_LOW` and both self-loops issue nothing. Each register picks one action per cycle, `ACT_CLEAR`, `ACT_STEP` or `ACT_HOLD`, in that priority. The serial data input is not synchronized. It is sampled in the cycle the shift strobe fires, so a chained instance sees the upstream stage value from before the shared shift.

Top module: `sipo_latch`

## Requirements
- R1: After system reset, with both clock pins low and both clear pins high, `par_out` is all zeros and `chain_out` is 0.
- R2: On a rising edge of `shift_clk_in` with `shift_clr_n_in` high, shift stage 0 loads `ser_in` and stage i loads the old stage i-1. Stage 0 reaches `par_out[0]` and stage N-1 reaches `par_out[N-1]` after a store.
- R3: A falling edge of `shift_clk_in`, or a level held steady, leaves the shift register unchanged. Likewise a falling edge of `store_clk_in` leaves `par_out` unchanged.
- R4: While `shift_clr_n_in` is low, the shift register is all zeros. A clear that arrives in the same synchronized cycle as a shift edge wins, and the edge is lost.
- R5: On a rising edge of `store_clk_in` with `store_clr_n_in` high, `par_out` takes the current shift-register contents.
- R6: While `store_clr_n_in` is low, `par_out` is all zeros. The shift register and `chain_out` are not affected, and a later store brings its contents back out.
- R7: `chain_out` equals shift stage N-1, not inverted. It follows shifts even when no store occurs.
- R8: When both clock pins rise together, `par_out` takes the shift contents from before that shift, so it stays one pulse behind.
- R9: A pin change made between system clock edges takes effect at the third following rising edge of `clk`. It has no effect at the first or second.
- R10: With the `chain_out` of one instance wired to the `ser_in` of the next, and both instances on common clock and clear pins, they behave as one register whose length is the sum of their widths. The widths may differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| ser_in | input | 1 | Serial data, sampled when a shift edge is processed |
| shift_clk_in | input | 1 | Shift clock pin, rising edge shifts |
| shift_clr_n_in | input | 1 | Active-low clear of the shift register |
| store_clk_in | input | 1 | Storage clock pin, rising edge captures |
| store_clr_n_in | input | 1 | Active-low clear of the storage register |
| par_out | output | N | Storage register contents, bit 0 is the first stage |
| chain_out | output | 1 | Last shift stage, for chaining |

## Verification
Two kinds of event can land in the same system cycle: a shift edge with a store edge (tied clocks), and a clear with a clock edge on the same register. The bench makes both happen by changing the relevant pins on the same falling edge of `clk`. Both pins then cross the equal-length synchronizers together and land in one cycle. It judges the results against a reference model. In the tied-clock case the store must capture the old shift value. In the clear-versus-edge case the edge must vanish. The result must also still hold after the clear is released while the clock pin stays high.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2
    } reg_act_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    localparam int SYNC_STAGES = 2;
    localparam int PIN_COUNT   = 4;

endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] flops;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flops <= {STAGES{RST_VAL}};
        end else begin
            flops <= {flops[STAGES-2:0], pin};
        end
    end

    assign level = flops[STAGES-1];

endmodule

// File: rtl/sipo_edge.sv
module sipo_edge
    import sipo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    lvl_state_e state_q;
    lvl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (level)  state_d = LVL_HIGH;
            LVL_HIGH: if (!level) state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = level;
            LVL_HIGH: rise = 1'b0;
        endcase
    end

    // R9: a level change yields a strobe of exactly one cycle
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/sipo_shift.sv
module sipo_shift
    import sipo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic         ser,
    output logic [N-1:0] q
);
    reg_act_e act;

    always_comb begin
        if (clr)       act = ACT_CLEAR;
        else if (step) act = ACT_STEP;
        else           act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= '0;
                ACT_STEP:  q <= {q[N-2:0], ser};
                ACT_HOLD:  q <= q;
                default:   q <= q;
            endcase
        end
    end

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (q[0] == $past(ser)) && (q[N-1] == $past(q[N-2])));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(q));

endmodule

// File: rtl/sipo_store.sv
module sipo_store
    import sipo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    reg_act_e act;

    always_comb begin
        if (clr)       act = ACT_CLEAR;
        else if (load) act = ACT_STEP;
        else           act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= '0;
                ACT_STEP:  q <= d;
                ACT_HOLD:  q <= q;
                default:   q <= q;
            endcase
        end
    end

    p_store_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (q == $past(d)));
    p_store_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(q));

endmodule

// File: rtl/sipo_latch.sv
module sipo_latch
    import sipo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         shift_clk_in,
    input  logic         shift_clr_n_in,
    input  logic         store_clk_in,
    input  logic         store_clr_n_in,
    output logic [N-1:0] par_out,
    output logic         chain_out
);
    // pin order: 0 shift clock, 1 shift clear, 2 store clock, 3 store clear
    localparam logic [PIN_COUNT-1:0] PIN_RST = 4'b1010;

    logic [PIN_COUNT-1:0] pins;
    logic [PIN_COUNT-1:0] lvl;
    logic                 shift_rise;
    logic                 store_rise;
    logic [N-1:0]         shift_q;

    assign pins = {store_clr_n_in, store_clk_in, shift_clr_n_in, shift_clk_in};

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_sync
        sipo_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(PIN_RST[i])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[i]),
            .level(lvl[i])
        );
    end

    sipo_edge u_shift_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(lvl[0]),
        .rise (shift_rise)
    );

    sipo_edge u_store_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(lvl[2]),
        .rise (store_rise)
    );

    sipo_shift #(.N(N)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .step (shift_rise),
        .clr  (!lvl[1]),
        .ser  (ser_in),
        .q    (shift_q)
    );

    sipo_store #(.N(N)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .load (store_rise),
        .clr  (!lvl[3]),
        .d    (shift_q),
        .q    (par_out)
    );

    assign chain_out = shift_q[N-1];

    p_tied_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_rise && store_rise && lvl[1] && lvl[3]) |=> (par_out == $past(shift_q)));
    p_store_clear_keeps_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[3] && lvl[1] && !shift_rise) |=> $stable(chain_out));

endmodule

// File: tb/sipo_latch_bench.sv
module sipo_latch_bench;
    localparam int N = 8;
    localparam int M = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic ser = 1'b0, sclk = 1'b0, sclr_n = 1'b1, rclk = 1'b0, rclr_n = 1'b1;
    logic [N-1:0] par_a;
    logic         chain_a;
    logic [M-1:0] par_b;
    logic         chain_b;

    sipo_latch #(.N(N)) u_sipo_latch (
        .clk(clk), .rst_n(rst_n), .ser_in(ser),
        .shift_clk_in(sclk), .shift_clr_n_in(sclr_n),
        .store_clk_in(rclk), .store_clr_n_in(rclr_n),
        .par_out(par_a), .chain_out(chain_a));

    sipo_latch #(.N(M)) u_tail (
        .clk(clk), .rst_n(rst_n), .ser_in(chain_a),
        .shift_clk_in(sclk), .shift_clr_n_in(sclr_n),
        .store_clk_in(rclk), .store_clr_n_in(rclr_n),
        .par_out(par_b), .chain_out(chain_b));

    logic [N-1:0] sh_a, st_a;
    logic [M-1:0] sh_b, st_b;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    function automatic logic [N-1:0] next_a(logic [N-1:0] r, logic b);
        return {r[N-2:0], b};
    endfunction
    function automatic logic [M-1:0] next_b(logic [M-1:0] r, logic b);
        return {r[M-2:0], b};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " par_a"}, 32'(par_a), 32'(st_a));
        chk({req, " chain_a"}, 32'(chain_a), 32'(sh_a[N-1]));
        chk({req, " par_b"}, 32'(par_b), 32'(st_b));
        chk({req, " chain_b"}, 32'(chain_b), 32'(sh_b[M-1]));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic model_shift(logic b);
        sh_b = next_b(sh_b, sh_a[N-1]);
        sh_a = next_a(sh_a, b);
    endtask

    task automatic do_shift(logic b);
        ser = b; sclk = 1'b1; settle(); model_shift(b);
        check_all("R2 shift rise");
        sclk = 1'b0; settle();
        check_all("R3 shift fall");
    endtask

    task automatic do_store();
        rclk = 1'b1; settle(); st_a = sh_a; st_b = sh_b;
        check_all("R5 store rise");
        rclk = 1'b0; settle();
        check_all("R3 store fall");
    endtask

    task automatic do_tied(logic b);
        ser = b; sclk = 1'b1; rclk = 1'b1; settle();
        st_a = sh_a; st_b = sh_b; model_shift(b);
        check_all("R8 tied clocks");
        sclk = 1'b0; rclk = 1'b0; settle();
    endtask

    task automatic do_sclr();
        sclr_n = 1'b0; settle(); sh_a = '0; sh_b = '0;
        check_all("R4 shift clear");
        sclr_n = 1'b1; settle();
    endtask

    task automatic do_rclr();
        rclr_n = 1'b0; settle(); st_a = '0; st_b = '0;
        check_all("R6 store clear");
        rclr_n = 1'b1; settle();
    endtask

    task automatic do_clr_on_edge(logic b);
        ser = b; sclr_n = 1'b0; sclk = 1'b1; settle(); sh_a = '0; sh_b = '0;
        check_all("R4 clear beats edge");
        sclr_n = 1'b1; settle();
        check_all("R4 edge lost after release");
        sclk = 1'b0; settle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sh_a = '0; st_a = '0; sh_b = '0; st_b = '0;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check_all("R1 reset");

        // directed: R2 ordering, bit 0 is the first stage
        do_shift(1'b1);
        do_store();
        chk("R2 first stage at par_out[0]", 32'(par_a), 32'h1);
        for (int i = 0; i < N - 2; i++) do_shift(1'b0);
        do_store();
        chk("R2 stage N-2", 32'(par_a), 32'(1 << (N - 2)));
        // R7 chain follows shift without store
        do_shift(1'b0);
        chk("R7 chain without store", 32'(chain_a), 32'h1);
        chk("R7 storage unchanged", 32'(par_a), 32'(1 << (N - 2)));

        // R9 latency: the next shift moves the 1 from stage N-1 into the tail
        ser = 1'b1; sclk = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 no change after two edges", 32'(chain_a), 32'h1);
        @(negedge clk);
        chk("R9 change at third edge", 32'(chain_a), 32'h0);
        @(negedge clk);
        model_shift(1'b1);
        check_all("R9 after shift");
        sclk = 1'b0; settle();

        // R6 store clear leaves shift intact
        do_store();
        do_rclr();
        chk("R6 chain unaffected", 32'(chain_a), 32'(sh_a[N-1]));
        do_store();
        chk("R6 contents return", 32'(par_a), 32'(sh_a));

        // R10 fill the tail through the chain
        for (int i = 0; i < N + M; i++) do_shift(1'(i % 3 == 0));
        do_store();
        check_all("R10 chained fill");

        do_tied(1'b1);
        do_tied(1'b0);
        do_clr_on_edge(1'b1);

        // mixed random operations
        for (int k = 0; k < 160; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4)       do_shift(1'($urandom_range(0, 1)));
            else if (op < 6)  do_store();
            else if (op == 6) do_tied(1'($urandom_range(0, 1)));
            else if (op == 7) do_sclr();
            else if (op == 8) do_rclr();
            else              do_clr_on_edge(1'($urandom_range(0, 1)));
        end
        do_store();
        check_all("R10 final");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule